// File: doc/BRIEF.md
# Program-Counter Domain Data Access Guard

This block sits beside the execute stage of a simple in-order core and decides, for every instruction, whether the code that is running may do what it is asking to do. Permission depends on where the program counter is. The guard sorts the current PC into one of three kinds of domain. A trusted primary domain is defined by one base/length pair. Up to `NSLOT` untrusted secondary domains each have their own code interval. Any PC outside all of these falls into no domain. A load or store is allowed at once when the PC is primary. In a secondary domain it is allowed only when the data address lies inside the data window of that slot. From no domain it is never allowed. The grant is combinational, so the core can suppress the memory or cache request in the same cycle, and this includes requests on a speculative path.

The guard also checks crossings between domains. A call from primary code into a secondary code interval stores its return site in a return register. A return from secondary code that lands in primary code must target exactly that stored address. Every violation produces a registered one-cycle trap pulse with a 2-bit cause.

The slots are set up through a configuration port, and only primary code may use it. A lock bit freezes a slot until primary code clears it. Every range register and the return register can be read back and written again, so a context switch can save and restore them.

Top module: `pc_domain_guard`

## Requirements
- R1: An access (ex_valid=1, ex_is_mem=1) whose PC is in the primary domain drives mem_ok=1 for any ex_addr, and no trap follows. The primary domain is pri_base <= PC < pri_base+pri_len, with the PC in no secondary code interval.
- R2: An access from a PC inside secondary slot i's code interval drives mem_ok=1 exactly when data_base <= ex_addr < data_base+data_len of slot i. Every window test uses the upper bound exclusive, and a length of 0 means an empty window.
- R3: mem_ok is combinational in the same cycle as the access. A denied access raises trap_valid=1 with trap_cause=2'b01 in the following cycle, and a granted access raises no trap.
- R4: When the PC lies in no secondary code interval and outside the primary window, every data access is denied and traps with cause 2'b01.
- R5: A call (ex_is_call=1) from primary code whose ex_target lies in a secondary code interval loads ex_pc+INSN_BYTES into the return register. Any other call leaves the return register unchanged.
- R6: A return (ex_is_ret=1) from secondary code whose ex_target is in the primary domain traps with cause 2'b10 unless ex_target equals the return register. A return whose target stays in a secondary interval does not trap.
- R7: Configuration address = {group[5:3], field[2:0]}. Groups 0..NSLOT-1 are slots with these fields: 0 code base, 1 code length, 2 data base, 3 data length, 4 control. Group NSLOT is global with these fields: 0 primary base, 1 primary length, 2 return register. An accepted write (ex_valid=1, cfg_we=1, primary PC) can be read on cfg_rdata (combinational from cfg_addr) from the next cycle.
- R8: While bit 0 of a slot's control word is set, writes to that slot are ignored. An accepted clear (cfg_clr=1, slot cfg_clr_idx) sets all five fields of the slot to zero, which disables it and makes it writable again.
- R9: A configuration write or clear issued with a non-primary PC is ignored and traps with cause 2'b11.
- R10: trap_valid is a one-cycle pulse per faulting instruction, and trap_cause is 2'b00 when there is no trap. When one instruction has several faults the cause priority is 11 over 10 over 01.
- R11: After reset the primary base is PRI_RST_BASE (0), the primary length is PRI_RST_LEN (0x8000_0000), every slot and the return register are zero, and no trap is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ex_valid | input | 1 | An instruction is in the execute stage |
| ex_pc | input | XLEN | PC of that instruction |
| ex_is_mem | input | 1 | Instruction is a load or store |
| ex_addr | input | XLEN | Data address of the load or store |
| ex_is_call | input | 1 | Instruction is a call |
| ex_is_ret | input | 1 | Instruction is a return |
| ex_target | input | XLEN | Call or return target |
| cfg_we | input | 1 | Configuration register write |
| cfg_clr | input | 1 | Slot clear operation |
| cfg_addr | input | 6 | Configuration register address (read and write) |
| cfg_wdata | input | XLEN | Configuration write data |
| cfg_clr_idx | input | 2 | Slot index to clear |
| cfg_rdata | output | XLEN | Configuration read data |
| mem_ok | output | 1 | Memory request may be issued this cycle |
| trap_valid | output | 1 | Trap pulse |
| trap_cause | output | 2 | Trap cause code |

## Verification
The data check is driven from a primary PC with an address far outside any window. It is also driven from a secondary PC at the first byte of the window, the last byte, one byte past the end and one byte below the base, and from a PC that belongs to no domain. Together these separate the three domain kinds and catch window bounds that are off by one. Return tests use a matching target, a mismatched target one word away and a target inside the secondary interval, and this shows that only secondary-to-primary crossings are compared. Configuration tests write from a secondary PC, write to a locked slot and then clear it, and an instruction with several faults at once shows the cause priority.

// File: rtl/pcg_pkg.sv
// Shared definitions for the PC domain guard: trap cause codes and the
// configuration field numbers. Assumes a 3-bit field part in every
// configuration address.
package pcg_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'b00,
        CAUSE_DATA = 2'b01,
        CAUSE_RET  = 2'b10,
        CAUSE_CFG  = 2'b11
    } cause_e;

    localparam int FLD_W = 3;

    // Slot group fields
    localparam logic [FLD_W-1:0] F_CODE_BASE = 3'd0;
    localparam logic [FLD_W-1:0] F_CODE_LEN  = 3'd1;
    localparam logic [FLD_W-1:0] F_DATA_BASE = 3'd2;
    localparam logic [FLD_W-1:0] F_DATA_LEN  = 3'd3;
    localparam logic [FLD_W-1:0] F_CTRL      = 3'd4;

    // Global group fields
    localparam logic [FLD_W-1:0] G_PRI_BASE  = 3'd0;
    localparam logic [FLD_W-1:0] G_PRI_LEN   = 3'd1;
    localparam logic [FLD_W-1:0] G_RET_ADDR  = 3'd2;

endpackage

// File: rtl/pcg_window.sv
// Half-open window test: hit when base <= value < base + len.
// The sum is formed one bit wider so a window that reaches the top of the
// address space does not wrap. A zero length never hits.
module pcg_window #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] value,
    input  logic [XLEN-1:0] base,
    input  logic [XLEN-1:0] len,
    output logic            hit
);
    localparam int EW = XLEN + 1;

    logic [EW-1:0] v_ext;
    logic [EW-1:0] lo_ext;
    logic [EW-1:0] hi_ext;

    // Compare the value against the widened bounds
    always_comb begin
        v_ext  = {1'b0, value};
        lo_ext = {1'b0, base};
        hi_ext = lo_ext + {1'b0, len};
        hit    = (len != '0) && (v_ext >= lo_ext) && (v_ext < hi_ext);
    end
endmodule

// File: rtl/pcg_classify.sv
// Sorts one address (a PC or a branch target) into a domain. Secondary code
// intervals are assumed disjoint. If several match anyway, the lowest index
// wins. The primary domain applies only when no secondary interval matches.
module pcg_classify #(
    parameter int XLEN  = 32,
    parameter int NSLOT = 4,
    localparam int IDXW = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic [XLEN-1:0]             pc,
    input  logic [NSLOT-1:0][XLEN-1:0]  code_base,
    input  logic [NSLOT-1:0][XLEN-1:0]  code_len,
    input  logic [XLEN-1:0]             pri_base,
    input  logic [XLEN-1:0]             pri_len,
    output logic                        is_pri,
    output logic                        is_sec,
    output logic [IDXW-1:0]             sec_idx
);
    logic [NSLOT-1:0] slot_hit;
    logic             pri_hit;

    for (genvar i = 0; i < NSLOT; i++) begin : g_code
        pcg_window #(.XLEN(XLEN)) u_win (
            .value(pc),
            .base (code_base[i]),
            .len  (code_len[i]),
            .hit  (slot_hit[i])
        );
    end

    pcg_window #(.XLEN(XLEN)) u_pri (
        .value(pc),
        .base (pri_base),
        .len  (pri_len),
        .hit  (pri_hit)
    );

    // Lowest matching slot index, primary only when no slot matches
    always_comb begin
        sec_idx = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (slot_hit[i]) sec_idx = IDXW'(i);
        end
        is_sec = |slot_hit;
        is_pri = !is_sec && pri_hit;
    end
endmodule

// File: rtl/pcg_regfile.sv
// Range registers of the guard. Writes and clears arrive already qualified
// (primary PC, valid instruction). A locked slot (control bit 0) ignores
// writes until it is cleared. The return register is loaded by
// domain-entering calls, and a call load takes precedence over a CSR write
// in the same cycle. The read port is combinational.
module pcg_regfile
    import pcg_pkg::*;
#(
    parameter int          XLEN        = 32,
    parameter int          NSLOT       = 4,
    parameter logic [31:0] PRI_RST_BASE = 32'h0000_0000,
    parameter logic [31:0] PRI_RST_LEN  = 32'h8000_0000,
    localparam int IDXW = (NSLOT > 1) ? $clog2(NSLOT) : 1,
    localparam int SELW = $clog2(NSLOT + 1),
    localparam int AW   = SELW + FLD_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [AW-1:0]               wr_addr,
    input  logic [XLEN-1:0]             wr_data,
    input  logic                        clr_en,
    input  logic [IDXW-1:0]             clr_idx,
    input  logic                        rar_load,
    input  logic [XLEN-1:0]             rar_value,
    input  logic [AW-1:0]               rd_addr,
    output logic [XLEN-1:0]             rd_data,
    output logic [NSLOT-1:0][XLEN-1:0]  code_base,
    output logic [NSLOT-1:0][XLEN-1:0]  code_len,
    output logic [NSLOT-1:0][XLEN-1:0]  data_base,
    output logic [NSLOT-1:0][XLEN-1:0]  data_len,
    output logic [NSLOT-1:0][XLEN-1:0]  slot_ctrl,
    output logic [XLEN-1:0]             pri_base,
    output logic [XLEN-1:0]             pri_len,
    output logic [XLEN-1:0]             rar
);
    logic [SELW-1:0]  wr_sel;
    logic [FLD_W-1:0] wr_fld;
    logic [SELW-1:0]  rd_sel;
    logic [FLD_W-1:0] rd_fld;

    assign wr_sel = wr_addr[AW-1:FLD_W];
    assign wr_fld = wr_addr[FLD_W-1:0];
    assign rd_sel = rd_addr[AW-1:FLD_W];
    assign rd_fld = rd_addr[FLD_W-1:0];

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        logic [XLEN-1:0] r_cbase;
        logic [XLEN-1:0] r_clen;
        logic [XLEN-1:0] r_dbase;
        logic [XLEN-1:0] r_dlen;
        logic [XLEN-1:0] r_ctrl;
        logic            clr_me;
        logic            wr_me;

        assign clr_me = clr_en && (clr_idx == IDXW'(i));
        assign wr_me  = wr_en && (wr_sel == SELW'(i)) && !r_ctrl[0];

        // Slot storage: reset or clear zeroes it, an unlocked write updates one field
        always_ff @(posedge clk) begin
            if (!rst_n || clr_me) begin
                r_cbase <= '0;
                r_clen  <= '0;
                r_dbase <= '0;
                r_dlen  <= '0;
                r_ctrl  <= '0;
            end else if (wr_me) begin
                case (wr_fld)
                    F_CODE_BASE: r_cbase <= wr_data;
                    F_CODE_LEN:  r_clen  <= wr_data;
                    F_DATA_BASE: r_dbase <= wr_data;
                    F_DATA_LEN:  r_dlen  <= wr_data;
                    F_CTRL:      r_ctrl  <= wr_data;
                    default: ;
                endcase
            end
        end

        assign code_base[i] = r_cbase;
        assign code_len[i]  = r_clen;
        assign data_base[i] = r_dbase;
        assign data_len[i]  = r_dlen;
        assign slot_ctrl[i] = r_ctrl;
    end

    logic glb_wr;
    assign glb_wr = wr_en && (wr_sel == SELW'(NSLOT));

    // Global registers: primary bounds and the return register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pri_base <= XLEN'(PRI_RST_BASE);
            pri_len  <= XLEN'(PRI_RST_LEN);
            rar      <= '0;
        end else begin
            if (glb_wr && wr_fld == G_PRI_BASE) pri_base <= wr_data;
            if (glb_wr && wr_fld == G_PRI_LEN)  pri_len  <= wr_data;
            if (rar_load)                         rar      <= rar_value;
            else if (glb_wr && wr_fld == G_RET_ADDR) rar   <= wr_data;
        end
    end

    // Read mux for save and restore
    always_comb begin
        rd_data = '0;
        if (rd_sel < SELW'(NSLOT)) begin
            case (rd_fld)
                F_CODE_BASE: rd_data = code_base[rd_sel[IDXW-1:0]];
                F_CODE_LEN:  rd_data = code_len[rd_sel[IDXW-1:0]];
                F_DATA_BASE: rd_data = data_base[rd_sel[IDXW-1:0]];
                F_DATA_LEN:  rd_data = data_len[rd_sel[IDXW-1:0]];
                F_CTRL:      rd_data = slot_ctrl[rd_sel[IDXW-1:0]];
                default:     rd_data = '0;
            endcase
        end else if (rd_sel == SELW'(NSLOT)) begin
            case (rd_fld)
                G_PRI_BASE: rd_data = pri_base;
                G_PRI_LEN:  rd_data = pri_len;
                G_RET_ADDR: rd_data = rar;
                default:    rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/pc_domain_guard.sv
// Execute-stage permission guard. It classifies ex_pc and ex_target into
// domains, grants data accesses combinationally (mem_ok), loads the return
// register on calls that enter a secondary domain, checks returns back to
// primary code, and registers any fault into a one-cycle trap pulse.
// It assumes one instruction per cycle and disjoint secondary intervals.
module pc_domain_guard
    import pcg_pkg::*;
#(
    parameter int          XLEN         = 32,
    parameter int          NSLOT        = 4,
    parameter int          INSN_BYTES   = 4,
    parameter logic [31:0] PRI_RST_BASE = 32'h0000_0000,
    parameter logic [31:0] PRI_RST_LEN  = 32'h8000_0000,
    localparam int IDXW = (NSLOT > 1) ? $clog2(NSLOT) : 1,
    localparam int AW   = $clog2(NSLOT + 1) + FLD_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ex_valid,
    input  logic [XLEN-1:0] ex_pc,
    input  logic            ex_is_mem,
    input  logic [XLEN-1:0] ex_addr,
    input  logic            ex_is_call,
    input  logic            ex_is_ret,
    input  logic [XLEN-1:0] ex_target,
    input  logic            cfg_we,
    input  logic            cfg_clr,
    input  logic [AW-1:0]   cfg_addr,
    input  logic [XLEN-1:0] cfg_wdata,
    input  logic [IDXW-1:0] cfg_clr_idx,
    output logic [XLEN-1:0] cfg_rdata,
    output logic            mem_ok,
    output logic            trap_valid,
    output logic [1:0]      trap_cause
);
    logic [NSLOT-1:0][XLEN-1:0] code_base;
    logic [NSLOT-1:0][XLEN-1:0] code_len;
    logic [NSLOT-1:0][XLEN-1:0] data_base;
    logic [NSLOT-1:0][XLEN-1:0] data_len;
    logic [NSLOT-1:0][XLEN-1:0] slot_ctrl;
    logic [XLEN-1:0]            pri_base;
    logic [XLEN-1:0]            pri_len;
    logic [XLEN-1:0]            rar;

    logic            cur_pri, cur_sec;
    logic [IDXW-1:0] cur_idx;
    logic            tgt_pri, tgt_sec;
    logic [IDXW-1:0] tgt_idx;
    logic            win_hit;
    logic            data_ok;
    logic            wr_en, clr_en, rar_load;
    logic            cfg_bad, ret_bad, data_bad;
    cause_e          next_cause;

    pcg_classify #(.XLEN(XLEN), .NSLOT(NSLOT)) u_cls_pc (
        .pc       (ex_pc),
        .code_base(code_base),
        .code_len (code_len),
        .pri_base (pri_base),
        .pri_len  (pri_len),
        .is_pri   (cur_pri),
        .is_sec   (cur_sec),
        .sec_idx  (cur_idx)
    );

    pcg_classify #(.XLEN(XLEN), .NSLOT(NSLOT)) u_cls_tgt (
        .pc       (ex_target),
        .code_base(code_base),
        .code_len (code_len),
        .pri_base (pri_base),
        .pri_len  (pri_len),
        .is_pri   (tgt_pri),
        .is_sec   (tgt_sec),
        .sec_idx  (tgt_idx)
    );

    pcg_window #(.XLEN(XLEN)) u_data_win (
        .value(ex_addr),
        .base (data_base[cur_idx]),
        .len  (data_len[cur_idx]),
        .hit  (win_hit)
    );

    // Grant, fault and update conditions for the current instruction
    always_comb begin
        data_ok  = cur_pri || (cur_sec && win_hit);
        mem_ok   = ex_valid && ex_is_mem && data_ok;
        data_bad = ex_valid && ex_is_mem && !data_ok;
        ret_bad  = ex_valid && ex_is_ret && cur_sec && tgt_pri && (ex_target != rar);
        cfg_bad  = ex_valid && (cfg_we || cfg_clr) && !cur_pri;
        wr_en    = ex_valid && cfg_we && cur_pri;
        clr_en   = ex_valid && cfg_clr && cur_pri;
        rar_load = ex_valid && ex_is_call && cur_pri && tgt_sec;
    end

    // Cause priority: configuration, then return, then data
    always_comb begin
        if (cfg_bad)       next_cause = CAUSE_CFG;
        else if (ret_bad)  next_cause = CAUSE_RET;
        else if (data_bad) next_cause = CAUSE_DATA;
        else               next_cause = CAUSE_NONE;
    end

    pcg_regfile #(
        .XLEN        (XLEN),
        .NSLOT       (NSLOT),
        .PRI_RST_BASE(PRI_RST_BASE),
        .PRI_RST_LEN (PRI_RST_LEN)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (cfg_addr),
        .wr_data  (cfg_wdata),
        .clr_en   (clr_en),
        .clr_idx  (cfg_clr_idx),
        .rar_load (rar_load),
        .rar_value(ex_pc + XLEN'(INSN_BYTES)),
        .rd_addr  (cfg_addr),
        .rd_data  (cfg_rdata),
        .code_base(code_base),
        .code_len (code_len),
        .data_base(data_base),
        .data_len (data_len),
        .slot_ctrl(slot_ctrl),
        .pri_base (pri_base),
        .pri_len  (pri_len),
        .rar      (rar)
    );

    // One-cycle trap pulse with its cause
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_valid <= 1'b0;
            trap_cause <= CAUSE_NONE;
        end else begin
            trap_valid <= (next_cause != CAUSE_NONE);
            trap_cause <= next_cause;
        end
    end
endmodule

// File: rtl/pcg_guard_checker.sv
// Assertion checker for pc_domain_guard, attached with bind below.
module pcg_guard_checker #(
    parameter int XLEN  = 32,
    parameter int NSLOT = 4,
    localparam int IDXW = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       ex_valid,
    input logic                       ex_is_mem,
    input logic                       cfg_we,
    input logic                       cfg_clr,
    input logic                       cur_pri,
    input logic                       mem_ok,
    input logic                       trap_valid,
    input logic [1:0]                 trap_cause,
    input logic                       clr_en,
    input logic [IDXW-1:0]            clr_idx,
    input logic [NSLOT-1:0][XLEN-1:0] slot_ctrl,
    input logic [NSLOT-1:0][XLEN-1:0] code_base,
    input logic [NSLOT-1:0][XLEN-1:0] code_len,
    input logic [NSLOT-1:0][XLEN-1:0] data_base,
    input logic [NSLOT-1:0][XLEN-1:0] data_len
);
    AST_PRI_NEVER_DENIED: assert property (@(posedge clk) disable iff (!rst_n)
        ex_valid && ex_is_mem && cur_pri |-> mem_ok); // R1

    AST_DENIAL_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        ex_valid && ex_is_mem && !mem_ok |=> trap_valid && trap_cause != 2'b00); // R3

    AST_GRANT_NO_DATA_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ok |=> !(trap_valid && trap_cause == 2'b01)); // R3

    AST_CFG_FROM_SEC_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        ex_valid && (cfg_we || cfg_clr) && !cur_pri |=> trap_valid && trap_cause == 2'b11); // R9

    AST_IDLE_CAUSE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_valid |-> trap_cause == 2'b00); // R10

    AST_NO_TRAP_WITHOUT_INSN: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_valid |=> !trap_valid); // R10

    for (genvar i = 0; i < NSLOT; i++) begin : g_lock
        AST_LOCKED_SLOT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
            slot_ctrl[i][0] && !(clr_en && clr_idx == IDXW'(i)) |=>
                $stable(code_base[i]) && $stable(code_len[i]) &&
                $stable(data_base[i]) && $stable(data_len[i]) &&
                $stable(slot_ctrl[i])); // R8
    end
endmodule

bind pc_domain_guard pcg_guard_checker #(.XLEN(XLEN), .NSLOT(NSLOT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ex_valid  (ex_valid),
    .ex_is_mem (ex_is_mem),
    .cfg_we    (cfg_we),
    .cfg_clr   (cfg_clr),
    .cur_pri   (cur_pri),
    .mem_ok    (mem_ok),
    .trap_valid(trap_valid),
    .trap_cause(trap_cause),
    .clr_en    (clr_en),
    .clr_idx   (cfg_clr_idx),
    .slot_ctrl (slot_ctrl),
    .code_base (code_base),
    .code_len  (code_len),
    .data_base (data_base),
    .data_len  (data_len)
);

// File: tb/pc_domain_guard_test.sv
// Directed bench for pc_domain_guard: one task per scenario.
module pc_domain_guard_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ex_valid = 1'b0;
    logic [31:0] ex_pc = '0;
    logic        ex_is_mem = 1'b0;
    logic [31:0] ex_addr = '0;
    logic        ex_is_call = 1'b0;
    logic        ex_is_ret = 1'b0;
    logic [31:0] ex_target = '0;
    logic        cfg_we = 1'b0;
    logic        cfg_clr = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [1:0]  cfg_clr_idx = '0;
    logic [31:0] cfg_rdata;
    logic        mem_ok;
    logic        trap_valid;
    logic [1:0]  trap_cause;

    int checks = 0;
    int fails  = 0;

    localparam logic [31:0] PRI_PC = 32'h0000_0100;
    // slot 1 fields, global fields
    localparam logic [5:0] A_S1_CBASE = 6'o10, A_S1_CLEN = 6'o11, A_S1_DBASE = 6'o12,
                           A_S1_DLEN = 6'o13, A_S1_CTRL = 6'o14, A_S0_CLEN = 6'o01,
                           A_PRI_BASE = 6'o40, A_PRI_LEN = 6'o41, A_RAR = 6'o42;

    always #5 clk = ~clk;

    pc_domain_guard uut (
        .clk(clk), .rst_n(rst_n), .ex_valid(ex_valid), .ex_pc(ex_pc),
        .ex_is_mem(ex_is_mem), .ex_addr(ex_addr), .ex_is_call(ex_is_call),
        .ex_is_ret(ex_is_ret), .ex_target(ex_target), .cfg_we(cfg_we),
        .cfg_clr(cfg_clr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_clr_idx(cfg_clr_idx), .cfg_rdata(cfg_rdata), .mem_ok(mem_ok),
        .trap_valid(trap_valid), .trap_cause(trap_cause)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Drive one instruction, sample mem_ok in its cycle and the trap after the edge
    task automatic run_op(input logic [31:0] pc, input logic m, input logic [31:0] a,
                          input logic c, input logic r, input logic [31:0] t,
                          input logic we, input logic clr, input logic [5:0] ca,
                          input logic [31:0] wd, input logic [1:0] ci,
                          output logic ok, output logic tv, output logic [1:0] tc);
        ex_valid = 1'b1; ex_pc = pc; ex_is_mem = m; ex_addr = a;
        ex_is_call = c; ex_is_ret = r; ex_target = t;
        cfg_we = we; cfg_clr = clr; cfg_addr = ca; cfg_wdata = wd; cfg_clr_idx = ci;
        #1 ok = mem_ok;
        @(posedge clk); #1;
        tv = trap_valid; tc = trap_cause;
        ex_valid = 1'b0; ex_is_mem = 1'b0; ex_is_call = 1'b0; ex_is_ret = 1'b0;
        cfg_we = 1'b0; cfg_clr = 1'b0;
    endtask

    task automatic mem(input logic [31:0] pc, input logic [31:0] a,
                       output logic ok, output logic tv, output logic [1:0] tc);
        run_op(pc, 1'b1, a, 1'b0, 1'b0, '0, 1'b0, 1'b0, '0, '0, '0, ok, tv, tc);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        logic ok, tv; logic [1:0] tc;
        run_op(PRI_PC, 1'b0, '0, 1'b0, 1'b0, '0, 1'b1, 1'b0, a, d, '0, ok, tv, tc);
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic setup_slot1();
        wr(A_S1_CBASE, 32'h9000_0000);
        wr(A_S1_CLEN,  32'h0000_0100);
        wr(A_S1_DBASE, 32'hA000_0000);
        wr(A_S1_DLEN,  32'h0000_0040);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R11", "trap_valid after reset", 32'(trap_valid), 32'd0);
        check("R10", "trap_cause idle", 32'(trap_cause), 32'd0);
        rd(A_PRI_LEN, d);  check("R11", "primary length", d, 32'h8000_0000);
        rd(A_PRI_BASE, d); check("R11", "primary base", d, 32'h0);
        rd(A_S0_CLEN, d);  check("R11", "slot0 code length", d, 32'h0);
        rd(A_RAR, d);      check("R11", "return register", d, 32'h0);
    endtask

    task automatic t_primary();
        logic ok, tv; logic [1:0] tc;
        mem(PRI_PC, 32'hFFFF_0000, ok, tv, tc);
        check("R1", "primary mem_ok", 32'(ok), 32'd1);
        check("R1", "primary no trap", 32'(tv), 32'd0);
    endtask

    task automatic t_config();
        logic [31:0] d;
        setup_slot1();
        rd(A_S1_CBASE, d); check("R7", "slot1 code base", d, 32'h9000_0000);
        rd(A_S1_DLEN, d);  check("R7", "slot1 data length", d, 32'h40);
        wr(A_RAR, 32'h0000_0300);
        rd(A_RAR, d);      check("R7", "return register restore", d, 32'h300);
    endtask

    task automatic t_secondary();
        logic ok, tv; logic [1:0] tc;
        mem(32'h9000_0010, 32'hA000_0000, ok, tv, tc);
        check("R2", "window first byte", 32'(ok), 32'd1);
        check("R3", "granted access no trap", 32'(tv), 32'd0);
        mem(32'h9000_0010, 32'hA000_003F, ok, tv, tc);
        check("R2", "window last byte", 32'(ok), 32'd1);
        mem(32'h9000_0010, 32'hA000_0040, ok, tv, tc);
        check("R2", "one past window", 32'(ok), 32'd0);
        check("R3", "denied trap valid", 32'(tv), 32'd1);
        check("R3", "denied trap cause", 32'(tc), 32'd1);
        mem(32'h9000_00FF, 32'h9FFF_FFFF, ok, tv, tc);
        check("R2", "one below window", 32'(ok), 32'd0);
    endtask

    task automatic t_nodomain();
        logic ok, tv; logic [1:0] tc;
        mem(32'hC000_0000, 32'h0000_0100, ok, tv, tc);
        check("R4", "no-domain mem_ok", 32'(ok), 32'd0);
        check("R4", "no-domain trap cause", {30'd0, tc}, 32'd1);
    endtask

    task automatic t_return();
        logic ok, tv; logic [1:0] tc; logic [31:0] d;
        run_op(32'h0000_0200, 1'b0, '0, 1'b1, 1'b0, 32'h9000_0000, 1'b0, 1'b0, '0, '0, '0, ok, tv, tc);
        rd(A_RAR, d); check("R5", "entry call records site", d, 32'h204);
        run_op(32'h0000_0400, 1'b0, '0, 1'b1, 1'b0, 32'h0000_0500, 1'b0, 1'b0, '0, '0, '0, ok, tv, tc);
        rd(A_RAR, d); check("R5", "primary-local call keeps register", d, 32'h204);
        run_op(32'h9000_0020, 1'b0, '0, 1'b0, 1'b1, 32'h0000_0204, 1'b0, 1'b0, '0, '0, '0, ok, tv, tc);
        check("R6", "matching return no trap", 32'(tv), 32'd0);
        run_op(32'h9000_0020, 1'b0, '0, 1'b0, 1'b1, 32'h0000_0208, 1'b0, 1'b0, '0, '0, '0, ok, tv, tc);
        check("R6", "mismatched return cause", {31'd0, tv} << 2 | 32'(tc), 32'h6);
        run_op(32'h9000_0020, 1'b0, '0, 1'b0, 1'b1, 32'h9000_0030, 1'b0, 1'b0, '0, '0, '0, ok, tv, tc);
        check("R6", "return inside secondary no trap", 32'(tv), 32'd0);
    endtask

    task automatic t_cfg_from_sec();
        logic ok, tv; logic [1:0] tc; logic [31:0] d;
        run_op(32'h9000_0010, 1'b0, '0, 1'b0, 1'b0, '0, 1'b1, 1'b0, A_S1_DLEN, 32'hFFFF, '0, ok, tv, tc);
        check("R9", "secondary write trap cause", {30'd0, tc}, 32'd3);
        rd(A_S1_DLEN, d); check("R9", "secondary write ignored", d, 32'h40);
        run_op(32'h9000_0010, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b1, '0, '0, 2'd1, ok, tv, tc);
        rd(A_S1_CLEN, d); check("R9", "secondary clear ignored", d, 32'h100);
    endtask

    task automatic t_lock();
        logic ok, tv; logic [1:0] tc; logic [31:0] d;
        wr(A_S1_CTRL, 32'h1);
        wr(A_S1_DLEN, 32'h80);
        rd(A_S1_DLEN, d); check("R8", "locked slot write ignored", d, 32'h40);
        mem(32'h9000_0010, 32'hA000_0050, ok, tv, tc);
        check("R8", "locked window unchanged", 32'(ok), 32'd0);
        run_op(PRI_PC, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b1, '0, '0, 2'd1, ok, tv, tc);
        rd(A_S1_CLEN, d); check("R8", "clear zeroes code length", d, 32'h0);
        rd(A_S1_CTRL, d); check("R8", "clear unlocks", d, 32'h0);
        mem(32'h9000_0010, 32'h0000_0010, ok, tv, tc);
        check("R4", "cleared slot PC outside domains", 32'(ok), 32'd0);
        wr(A_S1_DLEN, 32'h10);
        rd(A_S1_DLEN, d); check("R8", "write after clear", d, 32'h10);
    endtask

    task automatic t_priority();
        logic ok, tv; logic [1:0] tc;
        setup_slot1();
        run_op(32'h9000_0010, 1'b1, 32'hB000_0000, 1'b0, 1'b0, '0, 1'b1, 1'b0, A_S1_DLEN, 32'h1, '0, ok, tv, tc);
        check("R10", "combined fault cause", {30'd0, tc}, 32'd3);
        run_op(32'h9000_0010, 1'b1, 32'hB000_0000, 1'b0, 1'b1, 32'h0000_0999, 1'b0, 1'b0, '0, '0, '0, ok, tv, tc);
        check("R10", "return over data cause", {30'd0, tc}, 32'd2);
        @(posedge clk); #1;
        check("R10", "trap is single pulse", 32'(trap_valid), 32'd0);
        check("R10", "cause cleared after pulse", 32'(trap_cause), 32'd0);
    endtask

    initial begin
        #2_000_000;
        checks++; fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_primary();
        t_config();
        t_secondary();
        t_nodomain();
        t_return();
        t_cfg_from_sec();
        t_lock();
        t_priority();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule